// File: doc/BRIEF.md
# Four-Lane Skip-Column Rate Matcher

This block is the clock-compensation buffer on the receive side of a four-lane 8b/10b link. Each cycle of the recovered (write) clock it takes one decoded column: one character per lane, each with a control flag. It hands the columns to the local (read) clock domain in the same order. The two clocks may differ by up to ±100 PPM. The block absorbs that difference by changing the number of skip columns only. A skip column is one in which every lane is a control character of value 0x1C. When the buffer runs too full, an incoming skip column is dropped. When it runs too empty, a skip column that is being read is presented twice. No other column is ever added or removed.

The buffer stays idle while the link is not ready. Link-ready needs every lane to report word-boundary lock and the lane-to-lane deskew to report success. While the link is not ready, the buffer is held in its cleared state and its output carries idle columns. Each deletion is reported by a one-cycle pulse in the write domain. Each insertion is reported by a one-cycle pulse in the read domain. Hard overflow and underflow raise sticky error flags and re-centre the buffer to half full.

Top module: `skip_rate_matcher`

## Requirements
- R1: While any bit of `lane_sync` is 0 or `deskew_done` is 0, the output is the idle column (all `out_ctl` bits 1, every lane byte 0x07). `ins_pulse` and `del_pulse` stay 0 and no input column reaches the output.
- R2: Only a column with all four control flags set and all four bytes 0x1C may be dropped or duplicated. Every other column passes unchanged and in order. This includes 0x7C and 0xBC control columns, and columns where only some lanes carry a control 0x1C.
- R3: A skip column that arrives while the write-side fill level is at or above 12 (of 16) is discarded. `del_pulse` is high for exactly one write-clock cycle for each discard.
- R4: When a skip column is read while the read-side fill level is at or below 4, the same column appears on two consecutive read cycles. `ins_pulse` is high with the second copy, and no stored column is repeated more than once.
- R5: After link-ready rises, the output remains idle until the read-side fill level has reached 8 (half of the 16 entries).
- R6: If the write side finds the buffer full, `ovf_err` sets and stays set. If the read side finds it empty, `udf_err` sets and stays set. In both cases the affected pointer is moved to half full.
- R7: With the write clock 100 PPM faster and then 100 PPM slower than the read clock, and one skip column in every 16, neither error flag sets and the data columns stay intact.
- R8: After reset the output is the idle column and `ins_pulse`, `del_pulse`, `ovf_err` and `udf_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered clock that carries incoming columns |
| rd_clk | input | 1 | Local clock for the output columns |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| lane_sync | input | 4 | Per-lane word-boundary lock status |
| deskew_done | input | 1 | Lane deskew completed status |
| in_ctl | input | 4 | Control flag per lane of the incoming column (write domain) |
| in_dat | input | 32 | Incoming lane bytes, lane i in bits 8i+7..8i |
| out_ctl | output | 4 | Control flag per lane of the outgoing column (read domain) |
| out_dat | output | 32 | Outgoing lane bytes, lane i in bits 8i+7..8i |
| ins_pulse | output | 1 | One read cycle per duplicated skip column |
| del_pulse | output | 1 | One write cycle per discarded skip column |
| ovf_err | output | 1 | Sticky overflow flag (write domain) |
| udf_err | output | 1 | Sticky underflow flag (read domain) |

## Verification
The hardest state to reach from the ports is a duplicated skip column. It needs the read-side fill level to fall to the low mark, and a ±100 PPM offset moves the level by only one column per ten thousand cycles. The bench therefore runs the write clock 100 PPM fast and then 100 PPM slow for 60,000 read cycles each. This drives the level past both marks while a tracked sequence of data, control and partial-skip columns is compared in order. The error paths, which compensation alone never reaches, are forced by stopping the read clock and then the write clock.

// File: rtl/rm_pkg.sv
`timescale 1ns/10fs
package rm_pkg;
   localparam int unsigned LANE_W = 8;
   localparam logic [LANE_W-1:0] SKIP_CHAR = 8'h1C;
   localparam logic [LANE_W-1:0] IDLE_CHAR = 8'h07;
endpackage

// File: rtl/rm_sync.sv
`timescale 1ns/10fs
module rm_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/rm_wr_side.sv
`timescale 1ns/10fs
module rm_wr_side
   import rm_pkg::*;
#(
   parameter int unsigned LANES   = 4,
   parameter int unsigned AW      = 4,
   parameter int unsigned HI_MARK = 12
) (
   input  logic                         wr_clk,
   input  logic                         rst_n,
   input  logic                         gate_w,
   input  logic [LANES-1:0]             in_ctl,
   input  logic [LANES*LANE_W-1:0]      in_dat,
   input  logic [AW:0]                  rptr_b,
   input  logic [AW-1:0]                rd_addr,
   output logic [LANES*(LANE_W+1)-1:0]  rd_col,
   output logic [AW:0]                  wgray,
   output logic                         del_pulse,
   output logic                         ovf_err
);
   localparam int unsigned DEPTH = 1 << AW;
   localparam int unsigned CW    = LANES * (LANE_W + 1);
   localparam logic [AW:0] HI_L   = (AW+1)'(HI_MARK);
   localparam logic [AW:0] FULL_L = (AW+1)'(DEPTH);
   localparam logic [AW:0] HALF_L = (AW+1)'(DEPTH / 2);

   logic [CW-1:0]    mem [DEPTH];
   logic [AW:0]      wptr, wptr_nx, fill;
   logic [LANES-1:0] lane_r;
   logic             skip_in, drop, over, wr_en;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_r[g] = in_ctl[g] && (in_dat[g*LANE_W +: LANE_W] == SKIP_CHAR);
   end
   assign skip_in = &lane_r;
   assign fill    = wptr - rptr_b;

   always_comb begin
      wptr_nx = wptr;
      drop    = 1'b0;
      over    = 1'b0;
      wr_en   = 1'b0;
      if (!gate_w) begin
         wptr_nx = '0;
      end else if (skip_in && fill >= HI_L) begin
         drop = 1'b1;
      end else if (fill >= FULL_L) begin
         over    = 1'b1;
         wptr_nx = rptr_b + HALF_L;
      end else begin
         wr_en   = 1'b1;
         wptr_nx = wptr + 1'b1;
      end
   end

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr      <= '0;
         wgray     <= '0;
         del_pulse <= 1'b0;
         ovf_err   <= 1'b0;
      end else begin
         wptr      <= wptr_nx;
         wgray     <= wptr_nx ^ (wptr_nx >> 1);
         del_pulse <= drop;
         if (over) ovf_err <= 1'b1;
      end
   end

   always_ff @(posedge wr_clk) begin
      if (wr_en) mem[wptr[AW-1:0]] <= {in_ctl, in_dat};
   end
   assign rd_col = mem[rd_addr];

   // R3: a discard is only ever reported for a full skip column
   assert_del_only_skip_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
      del_pulse |-> $past(skip_in));
   // R1: no discard while the link is not ready
   assert_gated_no_del_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !gate_w |=> !del_pulse);
endmodule

// File: rtl/rm_rd_side.sv
`timescale 1ns/10fs
module rm_rd_side
   import rm_pkg::*;
#(
   parameter int unsigned LANES   = 4,
   parameter int unsigned AW      = 4,
   parameter int unsigned LO_MARK = 4
) (
   input  logic                         rd_clk,
   input  logic                         rst_n,
   input  logic                         gate_r,
   input  logic [AW:0]                  wptr_b,
   input  logic [LANES*(LANE_W+1)-1:0]  rd_col,
   output logic [AW-1:0]                rd_addr,
   output logic [AW:0]                  rgray,
   output logic [LANES-1:0]             out_ctl,
   output logic [LANES*LANE_W-1:0]      out_dat,
   output logic                         ins_pulse,
   output logic                         udf_err
);
   localparam int unsigned DEPTH = 1 << AW;
   localparam int unsigned DW    = LANES * LANE_W;
   localparam logic [AW:0] LO_L   = (AW+1)'(LO_MARK);
   localparam logic [AW:0] HALF_L = (AW+1)'(DEPTH / 2);
   localparam logic [DW-1:0] IDLE_DAT = {LANES{IDLE_CHAR}};
   localparam logic [DW-1:0] SKIP_DAT = {LANES{SKIP_CHAR}};

   logic [AW:0]      rptr, rptr_nx, fill;
   logic [LANES-1:0] col_ctl, lane_r;
   logic [DW-1:0]    col_dat;
   logic             run, rep, skip_rd, hold, empty;

   assign col_ctl = rd_col[DW +: LANES];
   assign col_dat = rd_col[DW-1:0];
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_r[g] = col_ctl[g] && (col_dat[g*LANE_W +: LANE_W] == SKIP_CHAR);
   end
   assign skip_rd = &lane_r;
   assign fill    = wptr_b - rptr;
   assign empty   = (fill == '0);
   assign hold    = skip_rd && (fill <= LO_L) && !rep;
   assign rd_addr = rptr[AW-1:0];

   always_comb begin
      rptr_nx = rptr;
      if (!gate_r)          rptr_nx = '0;
      else if (run && empty) rptr_nx = wptr_b - HALF_L;
      else if (run && !hold) rptr_nx = rptr + 1'b1;
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr      <= '0;
         rgray     <= '0;
         run       <= 1'b0;
         rep       <= 1'b0;
         out_ctl   <= '1;
         out_dat   <= IDLE_DAT;
         ins_pulse <= 1'b0;
         udf_err   <= 1'b0;
      end else begin
         rptr      <= rptr_nx;
         rgray     <= rptr_nx ^ (rptr_nx >> 1);
         ins_pulse <= 1'b0;
         if (!gate_r) begin
            run     <= 1'b0;
            rep     <= 1'b0;
            out_ctl <= '1;
            out_dat <= IDLE_DAT;
         end else if (!run) begin
            out_ctl <= '1;
            out_dat <= IDLE_DAT;
            if (fill >= HALF_L) run <= 1'b1;
         end else if (empty) begin
            udf_err <= 1'b1;
            rep     <= 1'b0;
            out_ctl <= '1;
            out_dat <= IDLE_DAT;
         end else begin
            out_ctl   <= col_ctl;
            out_dat   <= col_dat;
            ins_pulse <= rep;
            rep       <= hold;
         end
      end
   end

   // R1: link not ready forces the idle column and no insertion
   assert_idle_gated_R1: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !gate_r |=> (out_ctl == '1 && out_dat == IDLE_DAT && !ins_pulse));
   // R4: the inserted column repeats the column of the previous cycle
   assert_dup_repeats_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
      ins_pulse |-> (out_dat == $past(out_dat) && out_ctl == $past(out_ctl)));
   // R2: only skip columns are ever duplicated
   assert_ins_is_skip_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
      ins_pulse |-> (out_ctl == '1 && out_dat == SKIP_DAT));
   // R4: never two insertions back to back
   assert_single_dup_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
      ins_pulse |=> !ins_pulse);
endmodule

// File: rtl/skip_rate_matcher.sv
`timescale 1ns/10fs
module skip_rate_matcher
   import rm_pkg::*;
#(
   parameter int unsigned LANES       = 4,
   parameter int unsigned FIFO_AW     = 4,
   parameter int unsigned HI_MARK     = 12,
   parameter int unsigned LO_MARK     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                    wr_clk,
   input  logic                    rd_clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        lane_sync,
   input  logic                    deskew_done,
   input  logic [LANES-1:0]        in_ctl,
   input  logic [LANES*LANE_W-1:0] in_dat,
   output logic [LANES-1:0]        out_ctl,
   output logic [LANES*LANE_W-1:0] out_dat,
   output logic                    ins_pulse,
   output logic                    del_pulse,
   output logic                    ovf_err,
   output logic                    udf_err
);
   localparam int unsigned DEPTH = 1 << FIFO_AW;
   localparam int unsigned HALF  = DEPTH / 2;
   localparam int unsigned CW    = LANES * (LANE_W + 1);

   if (HI_MARK <= HALF || HI_MARK >= DEPTH) begin : g_bad_hi
      $error("HI_MARK must lie strictly between half and full depth");
   end
   if (LO_MARK == 0 || LO_MARK >= HALF) begin : g_bad_lo
      $error("LO_MARK must lie strictly between empty and half depth");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   logic              link_up, gate_w, gate_r;
   logic [FIFO_AW:0]  wgray, rgray, wgray_r, rgray_w, wptr_r_b, rptr_w_b;
   logic [FIFO_AW-1:0] rd_addr;
   logic [CW-1:0]     rd_col;

   assign link_up = (&lane_sync) & deskew_done;

   rm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_gate_w (
      .clk(wr_clk), .rst_n(rst_n), .d(link_up), .q(gate_w));
   rm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_gate_r (
      .clk(rd_clk), .rst_n(rst_n), .d(link_up), .q(gate_r));
   rm_sync #(.W(FIFO_AW+1), .STAGES(SYNC_STAGES)) u_rptr_to_w (
      .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_w));
   rm_sync #(.W(FIFO_AW+1), .STAGES(SYNC_STAGES)) u_wptr_to_r (
      .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

   for (genvar b = 0; b <= FIFO_AW; b++) begin : g_g2b
      assign rptr_w_b[b] = ^rgray_w[FIFO_AW:b];
      assign wptr_r_b[b] = ^wgray_r[FIFO_AW:b];
   end

   rm_wr_side #(.LANES(LANES), .AW(FIFO_AW), .HI_MARK(HI_MARK)) u_wr (
      .wr_clk(wr_clk), .rst_n(rst_n), .gate_w(gate_w),
      .in_ctl(in_ctl), .in_dat(in_dat), .rptr_b(rptr_w_b),
      .rd_addr(rd_addr), .rd_col(rd_col), .wgray(wgray),
      .del_pulse(del_pulse), .ovf_err(ovf_err));

   rm_rd_side #(.LANES(LANES), .AW(FIFO_AW), .LO_MARK(LO_MARK)) u_rd (
      .rd_clk(rd_clk), .rst_n(rst_n), .gate_r(gate_r),
      .wptr_b(wptr_r_b), .rd_col(rd_col), .rd_addr(rd_addr), .rgray(rgray),
      .out_ctl(out_ctl), .out_dat(out_dat),
      .ins_pulse(ins_pulse), .udf_err(udf_err));
endmodule

// File: tb/skip_rate_matcher_tb.sv
`timescale 1ns/10fs
module skip_rate_matcher_tb_top;
   localparam logic [35:0] R_COL    = {4'hF, 32'h1C1C1C1C};
   localparam logic [35:0] IDLE_COL = {4'hF, 32'h07070707};

   typedef enum logic [1:0] {M_SKIP, M_TRACK, M_UNTRACK} mode_e;

   logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   real         wr_half = 2.0;
   bit          wr_run = 1'b1, rd_run = 1'b1, cmp_en = 1'b1, done = 1'b0;
   logic [3:0]  lane_sync, in_ctl, out_ctl;
   logic        deskew_done, ins_pulse, del_pulse, ovf_err, udf_err;
   logic [31:0] in_dat, out_dat;
   mode_e       mode = M_SKIP;
   int          checks = 0, errors = 0, del_cnt = 0, ins_cnt = 0, seq = 0;
   logic [35:0] exp_q [$];
   logic [35:0] prev_o = '0;

   always begin #(wr_half); if (wr_run) wr_clk = ~wr_clk; end
   always begin #2.0;      if (rd_run) rd_clk = ~rd_clk; end

   skip_rate_matcher dut_i (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
      .lane_sync(lane_sync), .deskew_done(deskew_done),
      .in_ctl(in_ctl), .in_dat(in_dat), .out_ctl(out_ctl), .out_dat(out_dat),
      .ins_pulse(ins_pulse), .del_pulse(del_pulse),
      .ovf_err(ovf_err), .udf_err(udf_err));

   task automatic chk(input bit ok, input string req, input logic [35:0] act,
                      input logic [35:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // stream: skip every 16, 0x7C and 0xBC columns, partial-skip columns, data
   function automatic logic [35:0] gen_col(int n);
      int k = n % 32;
      if (k == 0 || k == 16) return R_COL;
      if (k == 8)  return {4'hF, 32'h7C7C7C7C};
      if (k == 24) return {4'hF, 32'hBCBCBCBC};
      if (k == 4)  return {4'h7, 32'h1C1C1C1C};
      if (k == 20) return {4'hF, 32'h1C1C1C07};
      return {4'h0, n[23:16], n[15:8], n[7:0], n[7:0] ^ 8'h5A};
   endfunction

   always @(negedge wr_clk) begin
      logic [35:0] c;
      case (mode)
         M_SKIP:  c = R_COL;
         M_TRACK: begin
            c = gen_col(seq);
            if (c != R_COL) exp_q.push_back(c);
            seq++;
         end
         default: begin c = {4'h0, 8'hEE, seq[23:0]}; seq++; end
      endcase
      {in_ctl, in_dat} = c;
      if (del_pulse) del_cnt++;
   end

   always @(negedge rd_clk) begin
      logic [35:0] o, e;
      o = {out_ctl, out_dat};
      if (ins_pulse) begin
         ins_cnt++;
         chk(o == R_COL && o == prev_o, "R4 duplicate", o, R_COL);
      end
      if (o != R_COL && o != IDLE_COL && cmp_en) begin
         if (exp_q.size() == 0) chk(1'b0, "R2 unexpected column", o, '0);
         else begin
            e = exp_q.pop_front();
            chk(o == e, "R2 order", o, e);
         end
      end
      prev_o = o;
   end

   initial begin
      int del_fast, ins_fast, n;
      lane_sync = '0; deskew_done = 1'b0; in_ctl = '0; in_dat = '0;
      repeat (5) @(posedge rd_clk);
      #1 rst_n = 1'b1;
      @(negedge rd_clk);
      chk({out_ctl, out_dat} == IDLE_COL, "R8 idle", {out_ctl, out_dat}, IDLE_COL);
      chk({ins_pulse, del_pulse, ovf_err, udf_err} == 4'b0, "R8 flags",
          36'({ins_pulse, del_pulse, ovf_err, udf_err}), '0);

      // R1: every not-ready combination of status inputs
      for (int v = 0; v < 31; v++) begin
         lane_sync = v[3:0]; deskew_done = v[4];
         repeat (12) begin
            @(negedge rd_clk);
            chk({out_ctl, out_dat} == IDLE_COL, "R1 idle", {out_ctl, out_dat}, IDLE_COL);
            chk(!ins_pulse && !del_pulse, "R1 pulses", 36'({ins_pulse, del_pulse}), '0);
         end
      end

      @(negedge rd_clk);
      lane_sync = 4'hF; deskew_done = 1'b1;
      repeat (8) @(negedge rd_clk);
      chk({out_ctl, out_dat} == IDLE_COL, "R5 early", {out_ctl, out_dat}, IDLE_COL);
      n = 8;
      while ({out_ctl, out_dat} == IDLE_COL && n < 40) begin @(negedge rd_clk); n++; end
      chk(n >= 10 && n < 40, "R5 start", 36'(n), 36'd14);

      // R7: 100 PPM fast, then 100 PPM slow
      @(posedge wr_clk);
      wr_half = 1.9998; mode = M_TRACK;
      repeat (60000) @(posedge rd_clk);
      del_fast = del_cnt; ins_fast = ins_cnt;
      wr_half = 2.0002;
      repeat (60000) @(posedge rd_clk);
      chk(del_fast >= 1, "R3 deletions", 36'(del_fast), 36'd1);
      chk(ins_cnt - ins_fast >= 1, "R4 insertions", 36'(ins_cnt - ins_fast), 36'd1);
      chk(!ovf_err && !udf_err, "R7 no errors", 36'({ovf_err, udf_err}), '0);
      chk(exp_q.size() <= 20, "R7 in flight", 36'(exp_q.size()), 36'd20);

      // R6: stop the reader, then the writer
      @(posedge rd_clk); cmp_en = 1'b0;
      @(posedge wr_clk); mode = M_UNTRACK; wr_half = 2.0;
      @(negedge rd_clk); rd_run = 1'b0;
      repeat (40) @(posedge wr_clk);
      @(negedge wr_clk);
      chk(ovf_err == 1'b1, "R6 overflow", 36'(ovf_err), 36'd1);
      chk(udf_err == 1'b0, "R6 no underflow yet", 36'(udf_err), '0);
      wr_run = 1'b0; rd_run = 1'b1;
      repeat (60) @(negedge rd_clk);
      chk(udf_err == 1'b1, "R6 underflow", 36'(udf_err), 36'd1);
      chk(ovf_err == 1'b1, "R6 sticky", 36'(ovf_err), 36'd1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #700us;
      if (!done) begin
         checks++; errors++;
         $display("FAIL R7 watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule